// File: doc/BRIEF.md
# FIFO Status Interrupt Unit

This unit gathers six event sources from a serial slave peripheral's receive and transmit buffers and presents them as a register-style interrupt block. It holds a sticky state vector and an enable vector, and it has a test port that forces state bits. It drives one interrupt line per source. Each line is high when its state bit and its enable bit are both set.

The buffer datapaths only provide byte counts, configured buffer sizes, watermark settings and single-cycle error pulses. The unit builds the full, receive-level and transmit-level conditions from these inputs. Each of those three sources records an event only when its condition rises. Both watermarks are compared at 32-bit word granularity: a watermark is rounded up to the next multiple of 4 bytes. A watermark that is 0 or out of range never produces an event.

Software access arrives as plain strobes with data: write-1-to-clear on the state, a load of the enable vector, and a test write that sets state bits.

Top module: `spi_fifo_irq`

## Requirements
- R1: Bit order of the state, enable and interrupt vectors is: bit 0 rx full, bit 1 rx at-or-above level, bit 2 tx below level, bit 3 rx mode error, bit 4 rx overflow, bit 5 tx underflow. Each `irq_o` bit is the AND of its state bit and its enable bit. State bits latch whether or not they are enabled.
- R2: A clear strobe with ones in `clr_data` clears the matching state bits. If a set source and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: A test strobe sets the state bits that are one in `test_data`.
- R4: The rx level bit is set only on the cycle where `rx_avail >= watermark` turns true. While the count stays at or above the watermark, the bit does not set again after software clears it. It sets again only after the count drops below the watermark and rises back.
- R5: Watermarks are rounded up to a multiple of 4. For example, an rx watermark of 5 acts as 8: 4 bytes do not trigger the event and 8 bytes do. A tx watermark of 13 acts as 16: 15 bytes held triggers the event.
- R6: An rx watermark of 0, or one whose rounded value exceeds `rx_size`, never sets the rx level bit.
- R7: The tx level bit is set on the cycle where `tx_held < rounded tx watermark` turns true. It is edge triggered in the same way as R4.
- R8: A tx watermark of 0, or one larger than `tx_size`, never sets the tx level bit.
- R9: The rx full bit is set on the cycle where `rx_avail == rx_size` turns true, and not again while the buffer stays full.
- R10: The pulses `rx_mode_err`, `rx_ovf` and `tx_udf` set state bits 3, 4 and 5 respectively.
- R11: An enable strobe loads `en_data` into the enable vector. Reset clears the state, the enable vector and the edge history. After reset, a condition that is already true counts as a rising edge.
- R12: A stimulus shows up in `state_o` and `irq_o` after exactly one rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_avail | input | CNT_W | Bytes available in the rx buffer |
| rx_size | input | CNT_W | Configured rx buffer size in bytes |
| rx_wmark | input | CNT_W | Rx watermark in bytes |
| tx_held | input | CNT_W | Bytes held in the tx buffer |
| tx_size | input | CNT_W | Configured tx buffer size in bytes |
| tx_wmark | input | CNT_W | Tx watermark in bytes |
| rx_mode_err | input | 1 | Rx mode error pulse |
| rx_ovf | input | 1 | Rx overflow pulse |
| tx_udf | input | 1 | Tx underflow pulse |
| clr_we | input | 1 | Write-1-to-clear strobe |
| clr_data | input | 6 | Bits to clear |
| en_we | input | 1 | Enable load strobe |
| en_data | input | 6 | New enable vector |
| test_we | input | 1 | Test set strobe |
| test_data | input | 6 | Bits to force set |
| state_o | output | 6 | Sticky state vector |
| enable_o | output | 6 | Enable vector |
| irq_o | output | 6 | Interrupt lines |

## Verification
Every result of this unit is registered exactly once. A count change, pulse, clear, test write or enable write appears on `state_o`, `enable_o` and `irq_o` after the first rising edge that follows it. The bench changes inputs on the falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and sample. One directed check also samples just before that rising edge to confirm nothing has changed yet. The edge-triggered sources are checked over sequences of vectors, because whether a bit sets depends on the count in the previous cycle as well as the current one.

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_avail,
  input  logic [CNT_W-1:0] rx_size,
  input  logic [CNT_W-1:0] rx_wmark,
  input  logic [CNT_W-1:0] tx_held,
  input  logic [CNT_W-1:0] tx_size,
  input  logic [CNT_W-1:0] tx_wmark,
  input  logic             rx_mode_err,
  input  logic             rx_ovf,
  input  logic             tx_udf,
  input  logic             clr_we,
  input  logic [5:0]       clr_data,
  input  logic             en_we,
  input  logic [5:0]       en_data,
  input  logic             test_we,
  input  logic [5:0]       test_data,
  output logic [5:0]       state_o,
  output logic [5:0]       enable_o,
  output logic [5:0]       irq_o
);
  localparam int EW = CNT_W + 1;
  localparam logic [EW-1:0] WORD_MASK = {{(EW-2){1'b1}}, 2'b00};

  logic [EW-1:0] rx_wm_up, tx_wm_up;
  logic          full_c, rx_ge_c, tx_lt_c;
  logic [2:0]    hist;
  logic [5:0]    set_vec, clr_vec;

  assign rx_wm_up = ({1'b0, rx_wmark} + EW'(3)) & WORD_MASK;
  assign tx_wm_up = ({1'b0, tx_wmark} + EW'(3)) & WORD_MASK;

  assign full_c  = (rx_avail == rx_size);
  assign rx_ge_c = (rx_wmark != '0) && (rx_wm_up <= {1'b0, rx_size})
                   && ({1'b0, rx_avail} >= rx_wm_up);
  assign tx_lt_c = (tx_wmark != '0) && (tx_wmark <= tx_size)
                   && ({1'b0, tx_held} < tx_wm_up);

  assign set_vec = {tx_udf, rx_ovf, rx_mode_err,
                    tx_lt_c & ~hist[2], rx_ge_c & ~hist[1], full_c & ~hist[0]}
                   | (test_we ? test_data : 6'b0);
  assign clr_vec = clr_we ? clr_data : 6'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist     <= '0;
      state_o  <= '0;
      enable_o <= '0;
    end else begin
      hist    <= {tx_lt_c, rx_ge_c, full_c};
      state_o <= (state_o & ~clr_vec) | set_vec;
      if (en_we) enable_o <= en_data;
    end
  end

  assign irq_o = state_o & enable_o;
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_mode_err,
  input logic       rx_ovf,
  input logic       tx_udf,
  input logic       clr_we,
  input logic       en_we,
  input logic [5:0] en_data,
  input logic       test_we,
  input logic [5:0] test_data,
  input logic [5:0] state_o,
  input logic [5:0] enable_o,
  input logic [5:0] irq_o
);
  assert_irq_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~(state_o & enable_o)) == 6'b0);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((state_o & $past(state_o)) == $past(state_o)));

  assert_test_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_we |=> ((state_o & $past(test_data)) == $past(test_data)));

  assert_moderr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode_err |=> state_o[3]);

  assert_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> state_o[4]);

  assert_udf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_udf |=> state_o[5]);

  assert_enable_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (enable_o == $past(en_data)));

  assert_enable_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(enable_o));
endmodule

bind spi_fifo_irq spi_fifo_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_mode_err(rx_mode_err), .rx_ovf(rx_ovf),
  .tx_udf(tx_udf), .clr_we(clr_we), .en_we(en_we), .en_data(en_data),
  .test_we(test_we), .test_data(test_data), .state_o(state_o),
  .enable_o(enable_o), .irq_o(irq_o)
);

// File: tb/spi_fifo_irq_test.sv
module spi_fifo_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int NVEC = 16;
  // rx_avail, tx_held, rx_wmark, tx_wmark, clr, expected state
  localparam logic [43:0] VEC [NVEC] = '{
    {8'd4,  8'd32, 8'd5,  8'd16, 6'h00, 6'h00},
    {8'd8,  8'd32, 8'd5,  8'd16, 6'h00, 6'h02},
    {8'd12, 8'd32, 8'd5,  8'd16, 6'h02, 6'h00},
    {8'd4,  8'd32, 8'd5,  8'd16, 6'h00, 6'h00},
    {8'd8,  8'd32, 8'd5,  8'd16, 6'h00, 6'h02},
    {8'd8,  8'd12, 8'd5,  8'd13, 6'h02, 6'h04},
    {8'd8,  8'd8,  8'd5,  8'd13, 6'h04, 6'h00},
    {8'd8,  8'd16, 8'd5,  8'd13, 6'h00, 6'h00},
    {8'd8,  8'd15, 8'd5,  8'd13, 6'h00, 6'h04},
    {8'd8,  8'd0,  8'd5,  8'd0,  6'h04, 6'h00},
    {8'd8,  8'd0,  8'd5,  8'd68, 6'h00, 6'h00},
    {8'd64, 8'd0,  8'd65, 8'd68, 6'h00, 6'h01},
    {8'd64, 8'd0,  8'd0,  8'd68, 6'h01, 6'h00},
    {8'd60, 8'd0,  8'd64, 8'd68, 6'h00, 6'h00},
    {8'd64, 8'd0,  8'd64, 8'd68, 6'h00, 6'h03},
    {8'd0,  8'd0,  8'd0,  8'd0,  6'h3F, 6'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] rx_avail = '0, rx_size = 10'd64, rx_wmark = '0;
  logic [CW-1:0] tx_held = '0, tx_size = 10'd64, tx_wmark = '0;
  logic rx_mode_err = 0, rx_ovf = 0, tx_udf = 0;
  logic clr_we = 0, en_we = 0, test_we = 0;
  logic [5:0] clr_data = '0, en_data = '0, test_data = '0;
  logic [5:0] state_o, enable_o, irq_o;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_irq #(.CNT_W(CW)) uut (.*);

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr_we = 0; en_we = 0; test_we = 0;
    rx_mode_err = 0; rx_ovf = 0; tx_udf = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R11 reset state", state_o, 6'h00);
    chk("R11 reset enable", enable_o, 6'h00);
    @(negedge clk); rst_n = 1;
    en_we = 1; en_data = 6'h3F;
    step();
    chk("R11 enable load", enable_o, 6'h3F);
    chk("R1 state idle", state_o, 6'h00);

    // Table: R4 R5 R6 R7 R8 R9 R2
    for (int i = 0; i < NVEC; i++) begin
      rx_avail = CW'(VEC[i][43:36]);
      tx_held  = CW'(VEC[i][35:28]);
      rx_wmark = CW'(VEC[i][27:20]);
      tx_wmark = CW'(VEC[i][19:12]);
      clr_data = VEC[i][11:6];
      clr_we   = (VEC[i][11:6] != 0);
      step();
      chk($sformatf("R4 R5 R6 R7 R8 R9 vector %0d", i), state_o, VEC[i][5:0]);
    end

    // R2 set wins over clear
    test_we = 1; test_data = 6'h08; clr_we = 1; clr_data = 6'h08;
    step();
    chk("R2 set beats clear", state_o, 6'h08);
    chk("R1 irq follows enabled state", irq_o, 6'h08);

    // R3 test write
    test_we = 1; test_data = 6'h21;
    step();
    chk("R3 test write sets", state_o, 6'h29);

    // R1 gating by enable
    en_we = 1; en_data = 6'h01;
    step();
    chk("R1 irq masked", irq_o, 6'h01);
    chk("R1 state unaffected by enable", state_o, 6'h29);

    // R10 + R12 pulses, latency
    clr_we = 1; clr_data = 6'h3F;
    step();
    chk("R2 clear all", state_o, 6'h00);
    rx_mode_err = 1; rx_ovf = 1; tx_udf = 1;
    #1;
    chk("R12 no change before edge", state_o, 6'h00);
    step();
    chk("R10 pulses set bits 3 4 5", state_o, 6'h38);
    chk("R1 disabled bits latch without irq", irq_o, 6'h00);

    // R11 reset clears history: full held through reset refires
    rx_avail = 10'd64; rx_size = 10'd64;
    step();
    rst_n = 0;
    #1;
    chk("R11 reset clears state", state_o, 6'h00);
    chk("R11 reset clears enable", enable_o, 6'h00);
    chk("R11 reset clears irq", irq_o, 6'h00);
    @(negedge clk); rst_n = 1;
    step();
    chk("R9 R11 full after reset counts as edge", state_o, 6'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule